// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the device end of a three-wire serial register port. A controller supplies a serial clock, holds an active-low frame enable low for the length of one transfer and drives a single data line. Each frame opens with one reserved slot that the block discards. A direction bit follows, and then a seven-bit register address. All of these are sampled on rising clock edges.

On a write the controller sends sixteen data bits, most significant first. The word goes into the addressed entry of a small register bank on the first rising edge that occurs after the enable has returned high. On a read the block waits out a turnaround gap and then drives the addressed register back, most significant bit first, with a separate output-enable that marks when the data line belongs to the block. The whole block runs in the serial clock domain. The register contents are brought out as one flat vector so that neighbouring logic and the bench can see them.

Top module: `tw_reg_slave`

## Requirements
- R1: While `rst_n` is low at a rising `sclk` edge, every register is cleared to zero, and after such an edge `sdo_oe` is low.
- R2: Slots are counted from zero at each rising `sclk` edge with `en_n` low. Slot 0 is ignored whatever its value. Slot 1 selects the direction (0 = write, 1 = read). Slots 2 to 8 carry the address, most significant bit first.
- R3: In a write frame, slots 9 to 24 carry the data word, bit 15 first. The register keeps its old value until the first rising edge with `en_n` high after slot 24, and holds the new word from that edge on.
- R4: If `en_n` rises before slot 24 of a write frame has been sampled, no register changes.
- R5: In a read frame, `sdo_oe` rises at the edge that samples slot 11, which is three edges after the last address bit. `sdo` carries bit 15 from that edge and moves to the next lower bit at each later rising edge, so bit 0 is presented from the edge of slot 26.
- R6: In a read frame, `sdo_oe` falls at the edge of slot 27 and stays low for the rest of the frame.
- R7: Only addresses 0 to NREGS-1 (default 8) are implemented. A read from any other address returns all zeros. A write to any other address changes no register, even when its low address bits match an implemented entry.
- R8: `en_n` going high clears the slot counter and `sdo_oe` at once without waiting for a clock edge. The next frame therefore starts at slot 0 even after an aborted one.
- R9: A write changes only the addressed register, and a read changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; all sampling and updates use its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| en_n | input | 1 | Active-low frame enable; high clears the frame state at once |
| sdi | input | 1 | Serial data from the controller |
| sdo | output | 1 | Serial read data, valid while `sdo_oe` is high |
| sdo_oe | output | 1 | High while the block owns the data line |
| regs_o | output | NREGS*DW (128) | Register bank contents, entry i at bits i*DW +: DW |

## Verification
The embedded properties watch the same things on every cycle. The output enable appears only inside the data window of a read frame, and it rises only at slot 11. Direction and address hold steady once their slots have passed. A pending write commits once and then clears. The bank stays unchanged on any edge without a commit, including a commit to an unimplemented address. What only the scenarios can show is whether the right value arrived. Every bit of each read-back word is compared, registers are checked before and after the commit edge, both values of the reserved slot are used, and aborted frames are followed at once by a full one to prove the slot counter realigned.

// File: rtl/tw_slave_pkg.sv
// Package: shared direction type and slot-position arithmetic for the
// three-wire register slave. Slot numbers count rising sclk edges inside a
// frame, starting from zero.
package tw_slave_pkg;

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } tw_dir_e;

    localparam int SLOT_DIR   = 1;   // direction bit position
    localparam int SLOT_ADDR0 = 2;   // first (most significant) address bit

    // Slot of the least significant address bit.
    function automatic int last_addr_slot(int aw);
        return SLOT_ADDR0 + aw - 1;
    endfunction

    // Slot of the least significant write data bit.
    function automatic int last_wdata_slot(int aw, int dw);
        return last_addr_slot(aw) + dw;
    endfunction

    // Edge at which the slave starts to drive: three after the last address bit.
    function automatic int first_rdata_slot(int aw);
        return last_addr_slot(aw) + 3;
    endfunction

    // Edge at which the slave lets go of the data line.
    function automatic int release_slot(int aw, int dw);
        return first_rdata_slot(aw) + dw;
    endfunction

    // Counter width able to hold one slot past the release slot (saturation value).
    function automatic int slot_width(int aw, int dw);
        return $clog2(release_slot(aw, dw) + 2);
    endfunction

endpackage

// File: rtl/tw_frame_ctrl.sv
// Module: frame control. Counts sampled slots while en_n is low and captures
// the direction bit and address. Assumes en_n changes away from rising sclk
// edges. en_n high clears all state asynchronously so each frame starts aligned.
module tw_frame_ctrl
    import tw_slave_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 16,
    parameter int CW = slot_width(AW, DW)
) (
    input  logic          sclk,
    input  logic          rst_n,
    input  logic          en_n,
    input  logic          sdi,
    output logic [CW-1:0] slot_o,
    output tw_dir_e       dir_o,
    output logic [AW-1:0] addr_o
);

    localparam logic [CW-1:0] S_DIR    = CW'(SLOT_DIR);
    localparam logic [CW-1:0] S_ADDR0  = CW'(SLOT_ADDR0);
    localparam logic [CW-1:0] S_A_LAST = CW'(last_addr_slot(AW));
    localparam logic [CW-1:0] S_MAX    = CW'(release_slot(AW, DW) + 1);

    logic [CW-1:0] slot_q;
    tw_dir_e       dir_q;
    logic [AW-1:0] addr_q;

    // Slot counter, direction and address capture; enable high clears at once.
    always_ff @(posedge sclk or posedge en_n) begin
        if (en_n) begin
            slot_q <= '0;
            dir_q  <= DIR_WRITE;
            addr_q <= '0;
        end else if (!rst_n) begin
            slot_q <= '0;
            dir_q  <= DIR_WRITE;
            addr_q <= '0;
        end else begin
            if (slot_q != S_MAX) begin
                slot_q <= slot_q + 1'b1;
            end
            if (slot_q == S_DIR) begin
                dir_q <= tw_dir_e'(sdi);
            end
            if (slot_q >= S_ADDR0 && slot_q <= S_A_LAST) begin
                addr_q <= {addr_q[AW-2:0], sdi};
            end
        end
    end

    assign slot_o = slot_q;
    assign dir_o  = dir_q;
    assign addr_o = addr_q;

    // R2: the direction holds for the rest of the frame once its slot has passed.
    p_dir_hold_r2: assert property (@(posedge sclk) disable iff (!rst_n)
        (!en_n && slot_q > S_DIR) |=> (en_n || $stable(dir_q)));

    // R2: the address holds once the last address bit has been taken.
    p_addr_hold_r2: assert property (@(posedge sclk) disable iff (!rst_n)
        (!en_n && slot_q > S_A_LAST) |=> (en_n || $stable(addr_q)));

endmodule

// File: rtl/tw_wr_path.sv
// Module: write path. Shifts the write data word in during a write frame and
// raises a pending flag once the last data bit has been sampled. The commit
// strobe is offered on the first rising edge with en_n high. A frame cut
// short never sets the flag, so nothing is committed. A pending word that
// sees no such edge before the next frame starts is dropped.
module tw_wr_path
    import tw_slave_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 16,
    parameter int CW = slot_width(AW, DW)
) (
    input  logic          sclk,
    input  logic          rst_n,
    input  logic          en_n,
    input  logic          sdi,
    input  logic [CW-1:0] slot_i,
    input  tw_dir_e       dir_i,
    input  logic [AW-1:0] addr_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o
);

    localparam logic [CW-1:0] S_D_FIRST = CW'(last_addr_slot(AW) + 1);
    localparam logic [CW-1:0] S_D_LAST  = CW'(last_wdata_slot(AW, DW));

    logic [DW-1:0] shift_q;
    logic [AW-1:0] paddr_q;
    logic          pend_q;

    // Data shifting, pending-word capture and pending clear on commit or new frame.
    always_ff @(posedge sclk) begin
        if (!rst_n) begin
            shift_q <= '0;
            paddr_q <= '0;
            pend_q  <= 1'b0;
        end else if (en_n) begin
            pend_q <= 1'b0;
        end else begin
            if (slot_i == '0) begin
                pend_q <= 1'b0;
            end
            if (dir_i == DIR_WRITE && slot_i >= S_D_FIRST && slot_i <= S_D_LAST) begin
                shift_q <= {shift_q[DW-2:0], sdi};
            end
            if (dir_i == DIR_WRITE && slot_i == S_D_LAST) begin
                pend_q  <= 1'b1;
                paddr_q <= addr_i;
            end
        end
    end

    assign wr_en_o   = pend_q & en_n;
    assign wr_addr_o = paddr_q;
    assign wr_data_o = shift_q;

    // R3: one commit per completed write frame, never on two edges in a row.
    p_single_commit_r3: assert property (@(posedge sclk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);

    // R4: a word becomes pending only while a frame is in progress.
    p_pend_in_frame_r4: assert property (@(posedge sclk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(!en_n));

endmodule

// File: rtl/tw_reg_bank.sv
// Module: register bank. Holds NREGS words, writes one on a commit strobe
// and returns zero for any address outside the implemented range. Assumes
// NREGS does not exceed 2**AW.
module tw_reg_bank #(
    parameter int AW    = 7,
    parameter int DW    = 16,
    parameter int NREGS = 8
) (
    input  logic                sclk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [AW-1:0]       wr_addr_i,
    input  logic [DW-1:0]       wr_data_i,
    input  logic [AW-1:0]       rd_addr_i,
    output logic [DW-1:0]       rd_data_o,
    output logic [NREGS*DW-1:0] regs_o
);

    logic [DW-1:0] mem_q [NREGS];

    for (genvar gi = 0; gi < NREGS; gi++) begin : g_entry
        // One register entry: cleared by reset, loaded on a matching commit.
        always_ff @(posedge sclk) begin
            if (!rst_n) begin
                mem_q[gi] <= '0;
            end else if (wr_en_i && wr_addr_i == AW'(gi)) begin
                mem_q[gi] <= wr_data_i;
            end
        end
        assign regs_o[gi*DW +: DW] = mem_q[gi];
    end

    // Read selection with zero for unimplemented addresses.
    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (rd_addr_i == AW'(i)) begin
                rd_data_o = mem_q[i];
            end
        end
    end

    // R9: the bank changes only on an edge that carries a commit.
    p_hold_no_commit_r9: assert property (@(posedge sclk) disable iff (!rst_n)
        !wr_en_i |=> $stable(regs_o));

    // R7: a commit to an unimplemented address leaves the bank untouched.
    p_oob_write_r7: assert property (@(posedge sclk) disable iff (!rst_n)
        (wr_en_i && int'(wr_addr_i) >= NREGS) |=> $stable(regs_o));

endmodule

// File: rtl/tw_rd_shifter.sv
// Module: read shifter. In a read frame it loads the addressed word three
// edges after the last address bit, turns the output enable on, and shifts
// one bit per rising edge, MSB first. It releases the line one edge after
// the last bit. en_n high drops the enable asynchronously.
module tw_rd_shifter
    import tw_slave_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 16,
    parameter int CW = slot_width(AW, DW)
) (
    input  logic          sclk,
    input  logic          rst_n,
    input  logic          en_n,
    input  logic [CW-1:0] slot_i,
    input  tw_dir_e       dir_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          sdo_o,
    output logic          sdo_oe_o
);

    localparam logic [CW-1:0] S_R_FIRST = CW'(first_rdata_slot(AW));
    localparam logic [CW-1:0] S_R_LAST  = CW'(first_rdata_slot(AW) + DW - 1);
    localparam logic [CW-1:0] S_RELEASE = CW'(release_slot(AW, DW));

    logic [DW-1:0] shift_q;
    logic          oe_q;

    // Output word load, bit shifting and line ownership.
    always_ff @(posedge sclk or posedge en_n) begin
        if (en_n) begin
            shift_q <= '0;
            oe_q    <= 1'b0;
        end else if (!rst_n) begin
            shift_q <= '0;
            oe_q    <= 1'b0;
        end else if (dir_i == DIR_READ) begin
            if (slot_i == S_R_FIRST) begin
                shift_q <= rd_data_i;
                oe_q    <= 1'b1;
            end else if (slot_i > S_R_FIRST && slot_i <= S_R_LAST) begin
                shift_q <= {shift_q[DW-2:0], 1'b0};
            end else if (slot_i == S_RELEASE) begin
                oe_q <= 1'b0;
            end
        end
    end

    assign sdo_o    = oe_q & shift_q[DW-1];
    assign sdo_oe_o = oe_q;

    // R5: the line is owned only during a read frame.
    p_oe_read_only_r5: assert property (@(posedge sclk) disable iff (!rst_n)
        sdo_oe_o |-> (dir_i == DIR_READ));

    // R5: ownership starts exactly at the first read data slot.
    p_oe_start_r5: assert property (@(posedge sclk) disable iff (!rst_n)
        $rose(sdo_oe_o) |-> ($past(slot_i) == S_R_FIRST));

    // R6: ownership never outlasts the release slot.
    p_oe_window_r6: assert property (@(posedge sclk) disable iff (!rst_n)
        sdo_oe_o |-> (slot_i > S_R_FIRST && slot_i <= S_RELEASE));

endmodule

// File: rtl/tw_reg_slave.sv
// Module: top of the three-wire register slave. Wires frame control, the
// write path, the register bank and the read shifter together. Everything
// runs on sclk; moving register values into another clock domain is left to
// the surrounding logic.
module tw_reg_slave
    import tw_slave_pkg::*;
#(
    parameter int AW    = 7,
    parameter int DW    = 16,
    parameter int NREGS = 8
) (
    input  logic                sclk,
    input  logic                rst_n,
    input  logic                en_n,
    input  logic                sdi,
    output logic                sdo,
    output logic                sdo_oe,
    output logic [NREGS*DW-1:0] regs_o
);

    localparam int CW = slot_width(AW, DW);

    logic [CW-1:0] slot;
    tw_dir_e       dir;
    logic [AW-1:0] addr;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_data;

    tw_frame_ctrl #(.AW(AW), .DW(DW), .CW(CW)) u_frame (
        .sclk   (sclk),
        .rst_n  (rst_n),
        .en_n   (en_n),
        .sdi    (sdi),
        .slot_o (slot),
        .dir_o  (dir),
        .addr_o (addr)
    );

    tw_wr_path #(.AW(AW), .DW(DW), .CW(CW)) u_wr (
        .sclk      (sclk),
        .rst_n     (rst_n),
        .en_n      (en_n),
        .sdi       (sdi),
        .slot_i    (slot),
        .dir_i     (dir),
        .addr_i    (addr),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data)
    );

    tw_reg_bank #(.AW(AW), .DW(DW), .NREGS(NREGS)) u_bank (
        .sclk      (sclk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (addr),
        .rd_data_o (rd_data),
        .regs_o    (regs_o)
    );

    tw_rd_shifter #(.AW(AW), .DW(DW), .CW(CW)) u_rd (
        .sclk      (sclk),
        .rst_n     (rst_n),
        .en_n      (en_n),
        .slot_i    (slot),
        .dir_i     (dir),
        .rd_data_i (rd_data),
        .sdo_o     (sdo),
        .sdo_oe_o  (sdo_oe)
    );

endmodule

// File: tb/tw_reg_slave_bench.sv
// Scoreboard bench: driver tasks push expected read words into a queue, and a
// monitor process rebuilds each word from sdo and compares it. Inputs change
// on falling sclk edges; outputs are sampled 5 ns after rising edges.
module tw_reg_slave_bench;

    localparam int AW = 7;
    localparam int DW = 16;
    localparam int NREGS = 8;

    typedef struct {
        logic [DW-1:0] val;
        string         req;
    } exp_item_t;

    logic sclk = 1'b0;
    logic rst_n = 1'b0;
    logic en_n = 1'b1;
    logic sdi = 1'b0;
    logic sdo;
    logic sdo_oe;
    logic [NREGS*DW-1:0] regs;

    int n_chk = 0;
    int n_bad = 0;
    int edges = 0;
    bit rd_abort = 1'b0;
    bit oe_prev = 1'b0;
    logic [DW-1:0] model [NREGS];
    exp_item_t exp_q [$];

    tw_reg_slave #(.AW(AW), .DW(DW), .NREGS(NREGS)) u_tw_reg_slave (
        .sclk   (sclk),
        .rst_n  (rst_n),
        .en_n   (en_n),
        .sdi    (sdi),
        .sdo    (sdo),
        .sdo_oe (sdo_oe),
        .regs_o (regs)
    );

    always #10 sclk = ~sclk;   // 50 MHz

    // Bench-side edge count within a frame (edges sampled with en_n low).
    always @(posedge sclk or posedge en_n) begin
        if (en_n) edges <= 0;
        else      edges <= edges + 1;
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_regs(string req);
        for (int i = 0; i < NREGS; i++) begin
            check(req, $sformatf("reg%0d", i), 32'(regs[i*DW +: DW]), 32'(model[i]));
        end
    endtask

    function automatic logic slot_bit(bit rd, logic [AW-1:0] a, logic [DW-1:0] d, int s, bit resv);
        if (s == 0) return resv;
        if (s == 1) return rd;
        if (s <= 8) return a[8 - s];
        if (!rd && s <= 24) return d[24 - s];
        return 1'b0;
    endfunction

    // Drive nslots sampled slots, then raise en_n on the next falling edge.
    task automatic drive_frame(bit rd, logic [AW-1:0] a, logic [DW-1:0] d, int nslots, bit resv);
        for (int s = 0; s < nslots; s++) begin
            @(negedge sclk);
            en_n = 1'b0;
            sdi  = slot_bit(rd, a, d, s, resv);
        end
        @(negedge sclk);
        en_n = 1'b1;
        sdi  = 1'b0;
    endtask

    task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d, bit resv, string req);
        drive_frame(1'b0, a, d, 25, resv);
        #1 check_regs("R3");             // R3: nothing written before the commit edge
        if (int'(a) < NREGS) model[a] = d;
        @(posedge sclk); #5;
        check_regs(req);
    endtask

    task automatic do_read(logic [AW-1:0] a, bit resv, string req);
        exp_item_t it;
        it.val = (int'(a) < NREGS) ? model[a] : '0;
        it.req = req;
        exp_q.push_back(it);
        drive_frame(1'b1, a, 16'h0, 29, resv);
        @(posedge sclk); #5;
        check_regs("R9");                // R9: a read leaves the bank alone
    endtask

    // Monitor: checks enable timing and rebuilds read words for the scoreboard.
    initial begin
        int nb = 0;
        logic [DW-1:0] word = '0;
        exp_item_t it;
        forever begin
            @(posedge sclk); #5;
            if (sdo_oe && !oe_prev) begin
                check("R5", "oe rise edge", 32'(edges), 32'd12);
                nb = 0;
                word = '0;
            end
            if (sdo_oe) begin
                word = {word[DW-2:0], sdo};
                nb++;
                if (nb == DW) begin
                    if (exp_q.size() == 0) begin
                        check("R5", "unexpected word", 32'(word), 32'hFFFF_FFFF);
                    end else begin
                        it = exp_q.pop_front();
                        check(it.req, "read word", 32'(word), 32'(it.val));
                    end
                end
            end
            if (!sdo_oe && oe_prev && !rd_abort) begin
                check("R6", "oe release edge", 32'(edges), 32'd28);
            end
            oe_prev = sdo_oe;
        end
    end

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL R1 watchdog: actual=timeout expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREGS; i++) model[i] = '0;
        repeat (3) @(negedge sclk);
        rst_n = 1'b1;
        @(posedge sclk); #5;
        check_regs("R1");
        check("R1", "oe after reset", 32'(sdo_oe), 32'd0);

        // R2/R3/R9: writes with both reserved-slot values
        do_write(7'd3, 16'hA5C3, 1'b1, "R3");
        do_write(7'd0, 16'h1234, 1'b0, "R2");
        do_write(7'd7, 16'hFFFF, 1'b1, "R9");
        do_write(7'd5, 16'h8001, 1'b0, "R3");

        // R5/R6: read back, MSB first
        do_read(7'd3, 1'b0, "R5");
        do_read(7'd0, 1'b1, "R2");
        do_read(7'd7, 1'b0, "R5");
        do_read(7'd5, 1'b1, "R5");

        // R7: unimplemented addresses (0x64 aliases entry 4 in its low bits)
        do_write(7'h64, 16'hDEAD, 1'b0, "R7");
        do_read(7'h64, 1'b0, "R7");
        do_read(7'd8, 1'b0, "R7");

        // R4: write cut short after 20 slots, then R8 realignment
        drive_frame(1'b0, 7'd3, 16'h0000, 20, 1'b0);
        repeat (2) @(posedge sclk);
        #5 check_regs("R4");
        do_write(7'd2, 16'h5555, 1'b1, "R8");

        // R8: read cut short in its data phase releases the line at once
        rd_abort = 1'b1;
        drive_frame(1'b1, 7'd2, 16'h0, 16, 1'b0);
        #1 check("R8", "oe after abort", 32'(sdo_oe), 32'd0);
        repeat (2) @(posedge sclk);
        #5 rd_abort = 1'b0;
        do_read(7'd2, 1'b0, "R8");
        do_read(7'd6, 1'b1, "R7");

        repeat (3) @(posedge sclk);
        #5 check("R5", "scoreboard empty", 32'(exp_q.size()), 32'd0);

        // R1: reset clears the bank again
        @(negedge sclk);
        rst_n = 1'b0;
        @(posedge sclk); #5;
        for (int i = 0; i < NREGS; i++) model[i] = '0;
        check_regs("R1");
        @(negedge sclk);
        rst_n = 1'b1;

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule